// File: doc/BRIEF.md
# Sequential Divider with Zero-Divisor Trap

This block divides one 32-bit operand by another over many clock cycles. It produces either a signed quotient or an unsigned quotient. A caller raises `start_i` for one cycle with the operands and the mode. The block accepts the request only while it is idle. A radix-2 restoring loop then runs, the block corrects the sign, and `done_o` pulses for one cycle with the result on `quotient_o`. The quotient keeps that value until the next accepted request.

A zero divisor is detected when the request is accepted, and no iteration is run. The quotient becomes 0 and a sticky divide-by-zero flag is set. A trap is raised only if the exception-enable input is high and the divide-zero mask input is low. The trap is a one-cycle exception request together with a cause register loaded with the divide-by-zero code. Any accepted request with a nonzero divisor clears the flag.

The controller has five states:
- IDLE accepts requests.
- LOOP runs one quotient bit per cycle.
- SIGNFIX writes the sign-corrected quotient.
- FINISH raises `done_o`.
- ZERODIV raises `done_o` for the zero-divisor case.

Transitions:
- IDLE goes to LOOP on a start with a nonzero divisor.
- IDLE goes to ZERODIV on a start with a zero divisor.
- LOOP goes to SIGNFIX after the 32nd step.
- SIGNFIX goes to FINISH.
- FINISH returns to IDLE.
- ZERODIV returns to IDLE.

Top module: `seq_divider`

## Requirements
- R1: While reset is low, and right after it is released, `quotient_o`, `done_o`, `dz_flag_o`, `exc_req_o` and `cause_o` are all 0.
- R2: With `signed_i`=0 and a nonzero divisor, `quotient_o` = floor(dividend/divisor) on plain 32-bit values. `done_o` is high for exactly one cycle, in the 34th cycle after the start edge.
- R3: With `signed_i`=1, both operands are two's complement. The quotient is truncated toward zero, with the same latency as R2.
- R4: A signed division of 0x80000000 by 0xFFFFFFFF returns 0x80000000.
- R5: A zero divisor sets `quotient_o` to 0 and sets `dz_flag_o`. `done_o` pulses in the first cycle after the start edge.
- R6: `dz_flag_o` stays set while the block is idle. It clears in the first cycle after a start with a nonzero divisor is accepted.
- R7: A zero divisor with `exc_enable_i`=1 and `dz_exc_mask_i`=0 raises `exc_req_o` for exactly the `done_o` cycle. It also loads `cause_o` with 5'd5, the divide-by-zero code.
- R8: A zero divisor with `exc_enable_i`=0, or with `dz_exc_mask_i`=1, raises no `exc_req_o` and leaves `cause_o` unchanged.
- R9: A start raised while a division is in progress is ignored. The result, the latency and `dz_flag_o` are all unaffected.
- R10: `quotient_o` holds its value while the block is idle and no start is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a division (taken only when idle) |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| exc_enable_i | input | 1 | Exception-enable status bit |
| dz_exc_mask_i | input | 1 | Configuration bit; 1 suppresses the divide-by-zero trap |
| quotient_o | output | 32 | Quotient of the last completed request |
| done_o | output | 1 | One-cycle completion pulse |
| dz_flag_o | output | 1 | Sticky divide-by-zero status |
| exc_req_o | output | 1 | One-cycle exception request |
| cause_o | output | 5 | Exception cause register |

## Verification
A division with a nonzero divisor completes 34 clock edges after the start edge. A zero-divisor request completes on the very next edge, and the exception request and cause are due in that same cycle. `dz_flag_o` is due one edge after the start edge in both cases. The bench drives the start on a falling edge. It then counts rising edges, sampling at each following falling edge until `done_o` appears. It compares the count with 34 or 1, captures the quotient, exception and cause in that cycle, and checks that `done_o` and `exc_req_o` are low one cycle later.

// File: rtl/seq_divider_pkg.sv
package seq_divider_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOOP    = 3'd1,
        ST_SIGNFIX = 3'd2,
        ST_FINISH  = 3'd3,
        ST_ZERODIV = 3'd4
    } div_state_e;

    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_DIV_ZERO = 5'd5;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
    import seq_divider_pkg::*;
#(
    parameter int STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic zero_div_i,
    output logic accept_o,
    output logic load_o,
    output logic step_o,
    output logic fix_o,
    output logic done_o,
    output logic busy_o
);
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    div_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOOP)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        load_o   = 1'b0;
        step_o   = 1'b0;
        fix_o    = 1'b0;
        done_o   = 1'b0;
        busy_o   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                if (start_i) begin
                    accept_o = 1'b1;
                    if (zero_div_i) begin
                        state_d = ST_ZERODIV;
                    end else begin
                        load_o  = 1'b1;
                        state_d = ST_LOOP;
                    end
                end
            end
            ST_LOOP: begin
                step_o = 1'b1;
                if (cnt_q == LAST)
                    state_d = ST_SIGNFIX;
            end
            ST_SIGNFIX: begin
                fix_o   = 1'b1;
                state_d = ST_FINISH;
            end
            ST_FINISH: begin
                done_o  = 1'b1;
                state_d = ST_IDLE;
            end
            ST_ZERODIV: begin
                done_o  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/div_iter.sv
module div_iter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] num_i,
    input  logic [WIDTH-1:0] den_i,
    output logic [WIDTH-1:0] result_o
);
    logic [WIDTH:0]   rem_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] den_q;
    logic             neg_q;

    logic [WIDTH-1:0] num_mag, den_mag;
    logic [WIDTH:0]   shifted;
    logic [WIDTH+1:0] trial;
    logic             fits;

    always_comb begin
        num_mag = (signed_i && num_i[WIDTH-1]) ? (~num_i + 1'b1) : num_i;
        den_mag = (signed_i && den_i[WIDTH-1]) ? (~den_i + 1'b1) : den_i;
        shifted = {rem_q[WIDTH-1:0], quo_q[WIDTH-1]};
        trial   = {1'b0, shifted} - {2'b00, den_q};
        fits    = !trial[WIDTH+1];
        result_o = neg_q ? (~quo_q + 1'b1) : quo_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            neg_q <= 1'b0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= num_mag;
            den_q <= den_mag;
            neg_q <= signed_i && (num_i[WIDTH-1] ^ den_i[WIDTH-1]);
        end else if (step_i) begin
            rem_q <= fits ? trial[WIDTH:0] : shifted;
            quo_q <= {quo_q[WIDTH-2:0], fits};
        end
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import seq_divider_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               signed_i,
    input  logic [WIDTH-1:0]   dividend_i,
    input  logic [WIDTH-1:0]   divisor_i,
    input  logic               exc_enable_i,
    input  logic               dz_exc_mask_i,
    output logic [WIDTH-1:0]   quotient_o,
    output logic               done_o,
    output logic               dz_flag_o,
    output logic               exc_req_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic zero_div, accept, load, step, fix, busy_w;
    logic [WIDTH-1:0] iter_result;
    logic trap;

    assign zero_div = (divisor_i == '0);
    assign trap     = accept && zero_div && exc_enable_i && !dz_exc_mask_i;

    div_ctrl #(.STEPS(WIDTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .zero_div_i (zero_div),
        .accept_o   (accept),
        .load_o     (load),
        .step_o     (step),
        .fix_o      (fix),
        .done_o     (done_o),
        .busy_o     (busy_w)
    );

    div_iter #(.WIDTH(WIDTH)) u_iter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .signed_i (signed_i),
        .num_i    (dividend_i),
        .den_i    (divisor_i),
        .result_o (iter_result)
    );

    // quotient register and status/trap registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient_o <= '0;
            dz_flag_o  <= 1'b0;
            exc_req_o  <= 1'b0;
            cause_o    <= '0;
        end else begin
            exc_req_o <= trap;
            if (trap)
                cause_o <= CAUSE_DIV_ZERO;
            if (accept)
                dz_flag_o <= zero_div;
            if (accept && zero_div)
                quotient_o <= '0;
            else if (fix)
                quotient_o <= iter_result;
        end
    end
endmodule

// File: rtl/div_checker.sv
module div_checker
    import seq_divider_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [WIDTH-1:0]   divisor_i,
    input logic               exc_enable_i,
    input logic               dz_exc_mask_i,
    input logic               busy,
    input logic [WIDTH-1:0]   quotient_o,
    input logic               done_o,
    input logic               dz_flag_o,
    input logic               exc_req_o,
    input logic [CAUSE_W-1:0] cause_o
);
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_zero_quick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && divisor_i == '0) |=> (done_o && quotient_o == '0 && dz_flag_o));

    p_dz_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && divisor_i != '0) |=> !dz_flag_o);

    p_trap_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && divisor_i == '0 && exc_enable_i && !dz_exc_mask_i)
        |=> (exc_req_o && cause_o == CAUSE_DIV_ZERO));

    p_trap_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> (done_o && dz_flag_o));

    p_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && divisor_i == '0 && !(exc_enable_i && !dz_exc_mask_i))
        |=> (!exc_req_o && $stable(cause_o)));

    p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dz_flag_o));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> $stable(quotient_o));
endmodule

bind seq_divider div_checker #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .divisor_i     (divisor_i),
    .exc_enable_i  (exc_enable_i),
    .dz_exc_mask_i (dz_exc_mask_i),
    .busy          (busy_w),
    .quotient_o    (quotient_o),
    .done_o        (done_o),
    .dz_flag_o     (dz_flag_o),
    .exc_req_o     (exc_req_o),
    .cause_o       (cause_o)
);

// File: tb/test_seq_divider.sv
`timescale 1ns/1ps
module test_seq_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        exc_enable_i = 1'b0;
    logic        dz_exc_mask_i = 1'b0;
    logic [31:0] quotient_o;
    logic        done_o, dz_flag_o, exc_req_o;
    logic [4:0]  cause_o;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    seq_divider i_seq_divider (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .exc_enable_i(exc_enable_i), .dz_exc_mask_i(dz_exc_mask_i),
        .quotient_o(quotient_o), .done_o(done_o), .dz_flag_o(dz_flag_o),
        .exc_req_o(exc_req_o), .cause_o(cause_o)
    );

    // {signed, dividend, divisor, expected quotient}
    localparam int NV = 11;
    localparam logic [96:0] VEC [NV] = '{
        {1'b0, 32'd100,        32'd7,          32'd14},
        {1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF},
        {1'b0, 32'hFFFFFFFF,   32'h10,         32'h0FFFFFFF},
        {1'b0, 32'd5,          32'd9,          32'd0},
        {1'b0, 32'h80000000,   32'hFFFFFFFF,   32'd0},
        {1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD},
        {1'b1, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD},
        {1'b1, 32'hFFFFFF9C,   32'hFFFFFFF9,   32'd14},
        {1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000},
        {1'b1, 32'h80000000,   32'd2,          32'hC0000000},
        {1'b1, 32'd1000,       32'd3,          32'd333}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [31:0] r_q;
    int          r_lat;
    logic        r_exc, r_dz_early, r_cause_done, r_done_after, r_exc_after;
    logic [4:0]  r_cause;

    task automatic run_op(input logic sgn, input logic [31:0] a, input logic [31:0] b,
                          input logic en, input logic msk, input bit poke);
        @(negedge clk);
        signed_i = sgn; dividend_i = a; divisor_i = b;
        exc_enable_i = en; dz_exc_mask_i = msk; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        r_dz_early = dz_flag_o;
        r_lat = 1;
        while (!done_o && r_lat < 100) begin
            if (poke && r_lat == 10) begin
                start_i = 1'b1; dividend_i = 32'h12345678; divisor_i = 32'd0;
                exc_enable_i = 1'b1; dz_exc_mask_i = 1'b0; signed_i = ~sgn;
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            r_lat++;
        end
        start_i = 1'b0;
        r_q = quotient_o;
        r_exc = exc_req_o;
        r_cause = cause_o;
        @(posedge clk);
        @(negedge clk);
        r_done_after = done_o;
        r_exc_after = exc_req_o;
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 quotient in reset", quotient_o, 32'd0);
        chk("R1 done in reset", {31'd0, done_o}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 dz after reset", {31'd0, dz_flag_o}, 32'd0);
        chk("R1 exc after reset", {31'd0, exc_req_o}, 32'd0);
        chk("R1 cause after reset", {27'd0, cause_o}, 32'd0);

        // R2 / R3 / R4: vector table
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][96], VEC[i][95:64], VEC[i][63:32], 1'b0, 1'b0, 1'b0);
            if (VEC[i][96]) begin
                if (VEC[i][95:64] == 32'h80000000 && VEC[i][63:32] == 32'hFFFFFFFF)
                    chk("R4 min over minus one", r_q, VEC[i][31:0]);
                else
                    chk("R3 signed quotient", r_q, VEC[i][31:0]);
            end else begin
                chk("R2 unsigned quotient", r_q, VEC[i][31:0]);
            end
            chk("R2 latency", r_lat, 32'd34);
            chk("R2 done one cycle", {31'd0, r_done_after}, 32'd0);
        end

        // R10: quotient holds while idle
        held = quotient_o;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R10 quotient held", quotient_o, held);

        // R5 / R8: zero divisor with trap disabled
        run_op(1'b0, 32'd77, 32'd0, 1'b0, 1'b0, 1'b0);
        chk("R5 zero quotient", r_q, 32'd0);
        chk("R5 zero latency", r_lat, 32'd1);
        chk("R5 dz set", {31'd0, dz_flag_o}, 32'd1);
        chk("R8 no exc when disabled", {31'd0, r_exc}, 32'd0);
        chk("R8 cause unchanged", {27'd0, r_cause}, 32'd0);

        // R8: enabled but masked
        run_op(1'b1, 32'hFFFFFFF0, 32'd0, 1'b1, 1'b1, 1'b0);
        chk("R8 no exc when masked", {31'd0, r_exc}, 32'd0);
        chk("R8 cause unchanged masked", {27'd0, r_cause}, 32'd0);

        // R6: sticky while idle, cleared by nonzero start
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R6 dz sticky", {31'd0, dz_flag_o}, 32'd1);
        run_op(1'b0, 32'd9, 32'd3, 1'b0, 1'b0, 1'b0);
        chk("R6 dz cleared", {31'd0, r_dz_early}, 32'd0);
        chk("R2 after zero case", r_q, 32'd3);

        // R7: trap taken
        run_op(1'b0, 32'd50, 32'd0, 1'b1, 1'b0, 1'b0);
        chk("R7 exc request", {31'd0, r_exc}, 32'd1);
        chk("R7 cause code", {27'd0, r_cause}, 32'd5);
        chk("R7 exc one cycle", {31'd0, r_exc_after}, 32'd0);
        chk("R5 dz early", {31'd0, r_dz_early}, 32'd1);

        // R9: start during busy is ignored
        run_op(1'b0, 32'd1000, 32'd10, 1'b0, 1'b0, 1'b0);
        run_op(1'b0, 32'd200, 32'd8, 1'b0, 1'b0, 1'b1);
        chk("R9 quotient unaffected", r_q, 32'd25);
        chk("R9 latency unaffected", r_lat, 32'd34);
        chk("R9 dz unaffected", {31'd0, dz_flag_o}, 32'd0);
        chk("R9 no exc", {31'd0, r_exc}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule